// File: doc/BRIEF.md
# Column-Bypassing Unsigned Array Multiplier

This block multiplies two unsigned W-bit operands and produces the full 2W-bit product with no clock. The datapath is a carry-save array of full-adder cells followed by a ripple-carry adder. There is one cell row for each multiplier bit after bit 0. Inside every row, the cell at position i adds three bits. The first is the partial product of multiplicand bit i and the row's multiplier bit. The second is the running sum handed down from the row above. The third is the carry from the cell at the same position in the row above.

Every cell at position i is controlled by multiplicand bit i. When that bit is 0, the cell's three inputs are forced to zero by AND gates. The cell's output mux then forwards the sum from the row above unchanged and drives a zero carry. No carry is lost in this case, because every carry entering that position also comes from a bypassed cell. A whole diagonal of cells therefore stays idle for each zero bit in the multiplicand. The result is always identical to an ordinary multiply.

The low W product bits leave the array one per row. The high W bits come from the final ripple-carry adder, which merges the last row's sum and carry vectors.

Top module: `bp_col_mult`

## Requirements
- R1: For every pair of W-bit unsigned operands, prod_o equals md_i times mr_i as an unsigned 2W-bit value.
- R2: When md_i is all zeros, prod_o is zero for every value of mr_i, which means every cell is bypassed.
- R3: When mr_i is all zeros, prod_o is zero for every value of md_i.
- R4: When exactly one bit k of md_i is set, so that all other cell positions are bypassed, prod_o equals mr_i shifted left by k positions.
- R5: With both operands all ones, the longest carry path is exercised and prod_o equals (2^W-1)^2, with product bit 2W-1 and bit 0 both set.
- R6: At W = 4, the multiplicand 1010 times the multiplier 1111 bypasses cell positions 0 and 2 and gives the product 150 (hex 96).
- R7: Swapping the operands leaves prod_o unchanged, although a different set of cells is bypassed.
- R8: prod_o follows a change on md_i or mr_i combinationally, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| md_i | input | W | Multiplicand. Bit i enables or bypasses cell position i in every array row. |
| mr_i | input | W | Multiplier operand. Bit j selects the partial products added in row j. |
| prod_o | output | 2W | Unsigned product md_i * mr_i. |

## Verification
The bound checker examines every input change. It checks that the product matches an arithmetic multiply, that it is zero when either operand is zero, that it keeps the multiplier's bit count when only one multiplicand bit is set, and that both the top and bottom bits are set for the all-ones case. Operand symmetry needs two evaluations with the operands swapped, so only the bench scenarios show it. The same applies to the named 1010 by 1111 bypass pattern and to the product settling with no clock edge. The bench also walks every operand pair at W = 4.

// File: rtl/mulbp_pkg.sv
package mulbp_pkg;

  // Output pair of one array cell: sum goes down, carry goes to the next row
  typedef struct packed {
    logic s;
    logic c;
  } bp_sc_t;

endpackage

// File: rtl/bp_fa_cell.sv
module bp_fa_cell
  import mulbp_pkg::*;
(
  input  logic   md_bit,
  input  logic   mr_bit,
  input  logic   s_in,
  input  logic   c_in,
  output bp_sc_t res_o
);

  logic g_pp, g_s, g_c;
  logic fa_s, fa_c;

  always_comb begin
    // input isolation: gated to zero while the column is bypassed
    g_pp  = md_bit & mr_bit;
    g_s   = s_in & md_bit;
    g_c   = c_in & md_bit;
    fa_s  = g_pp ^ g_s ^ g_c;
    fa_c  = (g_pp & g_s) | (g_pp & g_c) | (g_s & g_c);
    // output mux selected by the multiplicand bit
    res_o.s = md_bit ? fa_s : s_in;
    res_o.c = md_bit ? fa_c : 1'b0;
  end

endmodule

// File: rtl/bp_csa_array.sv
module bp_csa_array
  import mulbp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] md,
  input  logic [W-1:0] mr,
  output logic [W-1:0] lo_o,
  output logic [W-2:0] sum_o,
  output logic [W-1:0] car_o
);

  localparam int NCELL = W * W;

  // flattened row-major planes: index j*W+i is row j, position i
  logic [NCELL-1:0] s_f;
  logic [NCELL-1:0] c_f;

  genvar i, j;
  generate
    for (i = 0; i < W; i++) begin : g_row0
      assign s_f[i] = md[i] & mr[0];
      assign c_f[i] = 1'b0;
    end

    for (j = 1; j < W; j++) begin : g_row
      for (i = 0; i < W; i++) begin : g_pos
        logic   s_up;
        bp_sc_t o;
        if (i == W-1) begin : g_edge
          assign s_up = 1'b0;
        end else begin : g_inner
          assign s_up = s_f[(j-1)*W + i + 1];
        end
        bp_fa_cell u_cell (
          .md_bit (md[i]),
          .mr_bit (mr[j]),
          .s_in   (s_up),
          .c_in   (c_f[(j-1)*W + i]),
          .res_o  (o)
        );
        assign s_f[j*W + i] = o.s;
        assign c_f[j*W + i] = o.c;
      end
    end

    for (j = 0; j < W; j++) begin : g_lo
      assign lo_o[j] = s_f[j*W];
    end
  endgenerate

  assign sum_o = s_f[(W-1)*W + 1 +: W-1];
  assign car_o = c_f[(W-1)*W +: W];

endmodule

// File: rtl/bp_ripple_add.sv
module bp_ripple_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] s
);

  logic [W-1:0] cy;

  assign cy[0] = 1'b0;

  genvar k;
  generate
    for (k = 0; k < W; k++) begin : g_bit
      assign s[k] = x[k] ^ y[k] ^ cy[k];
      if (k < W-1) begin : g_carry
        assign cy[k+1] = (x[k] & y[k]) | (x[k] & cy[k]) | (y[k] & cy[k]);
      end
    end
  endgenerate

endmodule

// File: rtl/bp_col_mult.sv
module bp_col_mult #(
  parameter int W = 8
) (
  input  logic [W-1:0]   md_i,
  input  logic [W-1:0]   mr_i,
  output logic [2*W-1:0] prod_o
);

  logic [W-1:0] lo_bits;
  logic [W-2:0] last_sum;
  logic [W-1:0] last_car;
  logic [W-1:0] hi_bits;

  bp_csa_array #(.W(W)) u_array (
    .md    (md_i),
    .mr    (mr_i),
    .lo_o  (lo_bits),
    .sum_o (last_sum),
    .car_o (last_car)
  );

  bp_ripple_add #(.W(W)) u_final (
    .x ({1'b0, last_sum}),
    .y (last_car),
    .s (hi_bits)
  );

  assign prod_o = {hi_bits, lo_bits};

endmodule

// File: rtl/bp_col_mult_chk.sv
module bp_col_mult_chk #(
  parameter int W = 8
) (
  input logic [W-1:0]   md_i,
  input logic [W-1:0]   mr_i,
  input logic [2*W-1:0] prod_o
);

  logic [2*W-1:0] ref_prod;

  always_comb begin
    ref_prod = (2*W)'(md_i) * (2*W)'(mr_i);

    a_r1_exact_product: assert (prod_o == ref_prod)
      else $error("R1 product %0h vs %0h", prod_o, ref_prod);

    if (md_i == '0) begin
      a_r2_zero_multiplicand: assert (prod_o == '0)
        else $error("R2 product %0h not zero", prod_o);
    end

    if (mr_i == '0) begin
      a_r3_zero_multiplier: assert (prod_o == '0)
        else $error("R3 product %0h not zero", prod_o);
    end

    if ($countones(md_i) == 1) begin
      a_r4_single_column: assert ($countones(prod_o) == $countones(mr_i))
        else $error("R4 bit count mismatch %0h", prod_o);
    end

    if ((&md_i) && (&mr_i)) begin
      a_r5_all_ones: assert (prod_o[2*W-1] && prod_o[0])
        else $error("R5 edge bits wrong %0h", prod_o);
    end
  end

endmodule

bind bp_col_mult bp_col_mult_chk #(.W(W)) i_chk (
  .md_i   (md_i),
  .mr_i   (mr_i),
  .prod_o (prod_o)
);

// File: tb/test_bp_col_mult.sv
module test_bp_col_mult;

  localparam int W  = 4;
  localparam int NV = 14;

  // each entry: {multiplicand, multiplier, expected product}
  localparam logic [15:0] VEC [NV] = '{
    16'h0000, 16'hAF96, 16'hFFE1, 16'h1F0F, 16'h8F78, 16'h0F00, 16'hF000,
    16'h5519, 16'h973F, 16'hC324, 16'h793F, 16'h6B42, 16'h3D27, 16'hEEC4
  };

  logic           clk;
  logic [W-1:0]   md;
  logic [W-1:0]   mr;
  logic [2*W-1:0] prod;
  int             n_chk;
  int             n_fail;

  bp_col_mult #(.W(W)) i_bp_col_mult (
    .md_i   (md),
    .mr_i   (mr),
    .prod_o (prod)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [2*W-1:0] got,
                       input logic [2*W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  // drive after a rising edge, sample in the middle of the cycle
  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b);
    @(posedge clk);
    #2;
    md = a;
    mr = b;
    #5;
  endtask

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [2*W-1:0] p_ab;
    n_chk  = 0;
    n_fail = 0;
    md = '0;
    mr = '0;
    #5;
    check("R2 idle state zero", prod, '0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      apply(VEC[v][15:12], VEC[v][11:8]);
      check("R1 table", prod, VEC[v][7:0]);
    end

    // R6: named bypass pattern
    apply(4'b1010, 4'b1111);
    check("R6 1010x1111", prod, 8'd150);

    // R5: longest carry path
    apply(4'hF, 4'hF);
    check("R5 all ones", prod, 8'd225);

    // R2 and R3: zero operands
    for (int k = 0; k < 16; k++) begin
      apply(4'h0, 4'(k));
      check("R2 md zero", prod, '0);
      apply(4'(k), 4'h0);
      check("R3 mr zero", prod, '0);
    end

    // R4: one active column
    for (int k = 0; k < W; k++) begin
      for (int b = 0; b < 16; b++) begin
        apply(4'(1 << k), 4'(b));
        check("R4 single column", prod, 8'(b << k));
      end
    end

    // R1 exhaustive and R7 operand swap
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        apply(4'(a), 4'(b));
        check("R1 exhaustive", prod, 8'(a * b));
        p_ab = prod;
        apply(4'(b), 4'(a));
        check("R7 swapped", prod, p_ab);
      end
    end

    // R8: changes between clock edges
    @(negedge clk);
    #3;
    md = 4'd7;
    mr = 4'd6;
    #1;
    check("R8 no edge first", prod, 8'd42);
    md = 4'd13;
    #1;
    check("R8 no edge md change", prod, 8'd78);
    mr = 4'd11;
    #1;
    check("R8 no edge mr change", prod, 8'd143);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule